// File: doc/BRIEF.md
# Multidrop Station Address Filter

This block sits between a 9-bit serial receiver and its receive FIFO. On a multidrop bus every character carries a ninth bit. When that bit is 1, the character is an address. When it is 0, the character is data. The block compares each address with a station address supplied by the host and decides which characters reach the FIFO.

When filtering is on, the block starts closed. An address equal to the station address opens the receiver. That address is written into the FIFO, and its ninth bit goes into the entry's parity-error slot. All data after it is accepted until the host closes the receiver or a foreign address arrives. A match can also raise a sticky line-status interrupt. When filtering is off, the block passes every character through unchanged.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, fifo_wr_o, irq_o, overrun_o and rx_open_o are all 0.
- R2: With filt_en_i = 0, every valid character is written with its 8 data bits unchanged, and fifo_perr_o equals rx_par_err_i. The receiver-open state has no effect.
- R3: With filt_en_i = 1 and the receiver closed, data characters (rx_bit9_i = 0) are discarded. Address characters (rx_bit9_i = 1) whose 8 data bits differ from station_addr_i are also discarded, and the receiver stays closed.
- R4: With filt_en_i = 1, an address equal to station_addr_i opens the receiver and is written with fifo_perr_o = 1 (its ninth bit).
- R5: A matching address sets irq_o only if lsi_en_i = 1. irq_o then stays 1 until a one-cycle pulse on irq_clr_i.
- R6: While the receiver is open with filtering on, each data character is written with fifo_perr_o = 0 (its ninth bit).
- R7: While the receiver is open, a non-matching address is dropped and closes the receiver.
- R8: While the receiver is open, a matching address is written again with fifo_perr_o = 1, and the receiver stays open.
- R9: host_disable_i closes the receiver. If host_disable_i and a matching address arrive in the same cycle, the address is written and the receiver stays open.
- R10: If a character should be written while fifo_full_i = 1, it is dropped and overrun_o is set. overrun_o is sticky until irq_clr_i, and a new set in the clear cycle wins. The receiver-open and interrupt updates still apply.
- R11: fifo_wr_o is a one-cycle pulse in the cycle after the clock edge at which rx_valid_i was sampled. fifo_wr_o is never 1 without such a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received data bits |
| rx_bit9_i | input | 1 | Ninth bit, 1 = address |
| rx_par_err_i | input | 1 | Parity error from receiver (used when filtering is off) |
| filt_en_i | input | 1 | Address filtering enable |
| station_addr_i | input | 8 | Station address to compare |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| host_disable_i | input | 1 | Host request to close the receiver |
| irq_clr_i | input | 1 | Clears the interrupt and overrun flags |
| fifo_full_i | input | 1 | FIFO cannot accept a write |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |
| fifo_perr_o | output | 1 | Parity-error slot of the FIFO entry |
| rx_open_o | output | 1 | Receiver-open state |
| irq_o | output | 1 | Line-status interrupt pending |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions run on every cycle and check these rules:
- Data and foreign addresses never reach the FIFO while the receiver is closed.
- A match always leaves the receiver open, and a foreign address always closes it.
- A full FIFO is never written.
- The interrupt flag holds until it is cleared.

The following can only be shown by the bench's scenarios:
- Exact data and parity-slot contents.
- The enable-gated interrupt.
- The collision between a host disable and a matching address.
- Overrun set-and-clear ordering.
- Pass-through when filtering is off.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              wr;
    logic [DATA_W-1:0] data;
    logic              perr;
  } fifo_req_t;
endpackage

// File: rtl/afl_classify.sv
module afl_classify #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  logic [DATA_W-1:0] station_i,
  input  logic              filt_en_i,
  output logic              addr_hit_o,
  output logic              addr_miss_o,
  output logic              data_o
);
  logic eq;
  assign eq          = (data_i == station_i);
  assign addr_hit_o  = valid_i & filt_en_i & bit9_i & eq;
  assign addr_miss_o = valid_i & filt_en_i & bit9_i & ~eq;
  assign data_o      = valid_i & ~bit9_i;
endmodule

// File: rtl/afl_gate.sv
module afl_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic miss_i,
  input  logic host_dis_i,
  output logic open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     open_o <= 1'b0;
    else if (hit_i)                  open_o <= 1'b1;  // match beats host disable
    else if (miss_i || host_dis_i)   open_o <= 1'b0;
  end
endmodule

// File: rtl/afl_sticky.sv
module afl_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import addr_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_bit9_i,
  input  logic              rx_par_err_i,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] station_addr_i,
  input  logic              lsi_en_i,
  input  logic              host_disable_i,
  input  logic              irq_clr_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_perr_o,
  output logic              rx_open_o,
  output logic              irq_o,
  output logic              overrun_o
);
  logic      hit, miss, is_data, want_wr;
  fifo_req_t req_d, req_q;

  afl_classify #(.DATA_W(DATA_W)) u_cls (
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .bit9_i     (rx_bit9_i),
    .station_i  (station_addr_i),
    .filt_en_i  (filt_en_i),
    .addr_hit_o (hit),
    .addr_miss_o(miss),
    .data_o     (is_data)
  );

  afl_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .miss_i    (miss),
    .host_dis_i(host_disable_i),
    .open_o    (rx_open_o)
  );

  always_comb begin
    if (!filt_en_i) want_wr = rx_valid_i;
    else            want_wr = hit | (is_data & rx_open_o);
    req_d.wr   = want_wr & ~fifo_full_i;
    req_d.data = rx_data_i;
    req_d.perr = filt_en_i ? rx_bit9_i : rx_par_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign fifo_wr_o   = req_q.wr;
  assign fifo_data_o = req_q.data;
  assign fifo_perr_o = req_q.perr;

  afl_sticky u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit & lsi_en_i),
    .clr_i (irq_clr_i),
    .flag_o(irq_o)
  );

  afl_sticky u_ovr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (want_wr & fifo_full_i),
    .clr_i (irq_clr_i),
    .flag_o(overrun_o)
  );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_bit9_i,
  input logic              filt_en_i,
  input logic [DATA_W-1:0] station_addr_i,
  input logic              irq_clr_i,
  input logic              fifo_full_i,
  input logic              fifo_wr_o,
  input logic              rx_open_o,
  input logic              irq_o
);
  // R3
  closed_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && filt_en_i && !rx_open_o && (!rx_bit9_i || rx_data_i != station_addr_i))
    |=> !fifo_wr_o);
  // R4
  match_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && filt_en_i && rx_bit9_i && rx_data_i == station_addr_i) |=> rx_open_o);
  // R7
  miss_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && filt_en_i && rx_bit9_i && rx_data_i != station_addr_i)
    |=> (!rx_open_o && !fifo_wr_o));
  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  // R10
  no_full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |=> !fifo_wr_o);
  // R11
  wr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !fifo_wr_o);
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(addr_filt_pkg::DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_i    (rx_valid_i),
  .rx_data_i     (rx_data_i),
  .rx_bit9_i     (rx_bit9_i),
  .filt_en_i     (filt_en_i),
  .station_addr_i(station_addr_i),
  .irq_clr_i     (irq_clr_i),
  .fifo_full_i   (fifo_full_i),
  .fifo_wr_o     (fifo_wr_o),
  .rx_open_o     (rx_open_o),
  .irq_o         (irq_o)
);

// File: tb/mdrop_addr_filter_tb.sv
module mdrop_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, rx_bit9 = 0, rx_perr = 0, filt_en = 0, lsi_en = 0;
  logic       host_dis = 0, irq_clr = 0, full = 0;
  logic [7:0] rx_data = '0, station = 8'h5A;
  logic       wr, perr, open, irq, ovr;
  logic [7:0] dout;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  mdrop_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_bit9_i(rx_bit9), .rx_par_err_i(rx_perr), .filt_en_i(filt_en),
    .station_addr_i(station), .lsi_en_i(lsi_en), .host_disable_i(host_dis),
    .irq_clr_i(irq_clr), .fifo_full_i(full), .fifo_wr_o(wr), .fifo_data_o(dout),
    .fifo_perr_o(perr), .rx_open_o(open), .irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic pe);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_bit9 = b9; rx_perr = pe;
    @(posedge clk); #1;
    rx_valid = 0; host_dis = 0; irq_clr = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(posedge clk); #1; irq_clr = 0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); host_dis = 1;
    @(posedge clk); #1; host_dis = 0;
  endtask

  task automatic t_reset();
    chk("R1 wr", wr, 0); chk("R1 irq", irq, 0);
    chk("R1 ovr", ovr, 0); chk("R1 open", open, 0);
  endtask

  task automatic t_passthru();
    filt_en = 0;
    send(8'h33, 1'b0, 1'b1);
    chk("R2 wr", wr, 1); chk("R2 data", dout, 8'h33); chk("R2 perr", perr, 1);
    send(8'hC4, 1'b1, 1'b0);
    chk("R2 wr addr", wr, 1); chk("R2 perr0", perr, 0); chk("R2 open", open, 0);
    @(posedge clk); #1;
    chk("R11 pulse ends", wr, 0);
  endtask

  task automatic t_closed();
    filt_en = 1; lsi_en = 0;
    send(8'h11, 1'b0, 1'b0);
    chk("R3 data drop", wr, 0);
    send(8'h5B, 1'b1, 1'b0);
    chk("R3 addr drop", wr, 0); chk("R3 stays closed", open, 0);
  endtask

  task automatic t_match_noirq();
    send(8'h5A, 1'b1, 1'b0);
    chk("R4 wr", wr, 1); chk("R4 data", dout, 8'h5A); chk("R4 perr", perr, 1);
    chk("R4 open", open, 1); chk("R5 no irq when disabled", irq, 0);
  endtask

  task automatic t_open_data();
    send(8'h77, 1'b0, 1'b1);
    chk("R6 wr", wr, 1); chk("R6 data", dout, 8'h77); chk("R6 perr", perr, 0);
  endtask

  task automatic t_rematch_irq();
    lsi_en = 1;
    send(8'h5A, 1'b1, 1'b0);
    chk("R8 wr", wr, 1); chk("R8 perr", perr, 1); chk("R8 open", open, 1);
    chk("R5 irq set", irq, 1);
    repeat (3) @(posedge clk); #1;
    chk("R5 irq sticky", irq, 1);
    pulse_clr();
    chk("R5 irq cleared", irq, 0);
  endtask

  task automatic t_mismatch();
    send(8'h01, 1'b1, 1'b0);
    chk("R7 drop", wr, 0); chk("R7 close", open, 0);
    send(8'h22, 1'b0, 1'b0);
    chk("R7 data after close", wr, 0);
  endtask

  task automatic t_host();
    lsi_en = 0;
    send(8'h5A, 1'b1, 1'b0);
    pulse_dis();
    chk("R9 host close", open, 0);
    send(8'h44, 1'b0, 1'b0);
    chk("R9 data dropped", wr, 0);
    send(8'h5A, 1'b1, 1'b0);
    @(negedge clk); host_dis = 1;
    send(8'h5A, 1'b1, 1'b0);
    chk("R9 collision wr", wr, 1); chk("R9 collision open", open, 1);
  endtask

  task automatic t_overrun();
    full = 1;
    send(8'h66, 1'b0, 1'b0);
    chk("R10 no wr", wr, 0); chk("R10 ovr", ovr, 1);
    send(8'h02, 1'b1, 1'b0);
    chk("R10 miss closes while full", open, 0);
    send(8'h5A, 1'b1, 1'b0);
    chk("R10 match opens while full", open, 1); chk("R10 no wr match", wr, 0);
    full = 0;
    @(negedge clk); irq_clr = 1;
    send(8'h10, 1'b0, 1'b0);
    chk("R10 data written", wr, 1); chk("R10 ovr cleared", ovr, 0);
    full = 1;
    @(negedge clk); irq_clr = 1;
    send(8'h12, 1'b0, 1'b0);
    chk("R10 set beats clear", ovr, 1);
    full = 0;
  endtask

  initial begin
    #1; t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_passthru();
    t_closed();
    t_match_noirq();
    t_open_data();
    t_rematch_irq();
    t_mismatch();
    t_host();
    t_overrun();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule